// File: doc/BRIEF.md
# Audio-Modem Link Global Status Register

This block holds the 16-bit global status word of a serial audio/modem codec link controller. It brings together three kinds of information in one readable word. Sticky event flags record a codec register read that timed out, a resume event on either serial data input, and a change of the codec's general-purpose inputs. Live mirrors show fields of the latest status slot received from the codec and the codec-ready indication of each input. Summary bits show whether any status bit of each DMA channel is set.

Software reads the word on `rd_data` and clears sticky flags by writing ones on `wr_data` with `wr_en` high. There are two resets, both asynchronous and active low, and each is released through a synchronizer. `rst_n` is the full power-on reset and clears everything. `pwr_rst_n` is the reset that comes with a return from the low-power state. It clears the live mirrors, but the sticky flags survive it, so software can still see which event woke the link.

Top module: `lnk_gsts_reg`

## Requirements
- R1: After `rst_n` is released, and with `codec_rdy` and `chan_sts` at zero, `rd_data` reads 0.
- R2: A `rd_timeout` pulse sets bit 15 at the next clock edge. The bit stays set through idle cycles until it is cleared by a write.
- R3: `resume_evt[1]` sets bit 11 and `resume_evt[0]` sets bit 10 at the next clock edge. Each bit then holds until it is cleared by a write.
- R4: A cycle with `slot_vld` high and `slot_bits[0]` = 1 sets bit 0 at the next edge. The bit then holds until it is cleared by a write.
- R5: A write with `wr_en` high clears each of sticky bits 15, 11, 10 and 0 whose `wr_data` bit is 1. A 0 in `wr_data` leaves the bit unchanged. If a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R6: Bits 14, 13 and 12 take `slot_bits[3]`, `[2]` and `[1]` at the edge that ends a cycle with `slot_vld` high. They hold their value while `slot_vld` is low.
- R7: Bits 9 and 8 show `codec_rdy[1]` and `codec_rdy[0]`, registered once, so they lag the input by one clock.
- R8: `chan_sts` carries five channels of `CH_STS_W` bits each. Channel k occupies `chan_sts[k*CH_STS_W +: CH_STS_W]`. Channels 0 to 4 are mic-in, PCM-out, PCM-in, modem-out and modem-in, and their summary bits are 7, 6, 5, 2 and 1. Each summary bit is the OR of its channel's field, without a register, and reads 0 as soon as the field is 0.
- R9: Bits 4 and 3 always read 0. Writes have no effect on bits 14 to 12, 9 to 1, or 4 and 3.
- R10: While `pwr_rst_n` is low, bits 14 to 12 and 9 to 8 read 0 and bits 15, 11, 10 and 0 keep their values. `rst_n` clears all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full power-on reset, asynchronous, active low |
| pwr_rst_n | input | 1 | Low-power exit reset, asynchronous, active low, clears mirrors only |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky bit |
| rd_data | output | 16 | Current status word |
| rd_timeout | input | 1 | Pulse: codec register read timed out |
| resume_evt | input | 2 | Per-input resume event pulses |
| slot_vld | input | 1 | Marks a valid received status slot |
| slot_bits | input | 4 | Low four bits of the received status slot |
| codec_rdy | input | 2 | Codec-ready indication per serial input |
| chan_sts | input | 5*CH_STS_W | Per-channel status bits, channel k at k*CH_STS_W |

## Verification
The summary bits have no register, so the bench checks them one time unit after it drives the inputs. The sweep covers every value of all channel fields. The sticky flags, the slot mirror and the ready bits change at the first clock edge after the stimulus. The bench drives inputs on the falling edge and compares on the next falling edge, which puts exactly one rising edge between drive and compare. Each reset releases only after the synchronizer stages. The bench therefore waits several cycles after each release before it checks anything, and it checks the mirror-clearing reset while that reset is still held.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_CH  = 5;
  localparam int NUM_IN  = 2;
  localparam int NUM_STK = 4;
  localparam int FLD_W   = 3;

  // sticky flag index within the flag vector
  localparam int STK_GPI  = 0;
  localparam int STK_RES0 = 1;
  localparam int STK_RES1 = 2;
  localparam int STK_TMO  = 3;

  // bit positions in the status word
  localparam int B_TMO     = 15;
  localparam int B_FLD_HI  = 14;
  localparam int B_FLD_LO  = 12;
  localparam int B_RES1    = 11;
  localparam int B_RES0    = 10;
  localparam int B_RDY_HI  = 9;
  localparam int B_RDY_LO  = 8;
  localparam int B_GPI     = 0;

  // channel index to summary bit position
  function automatic int chan_bit(input int k);
    case (k)
      0:       return 7;
      1:       return 6;
      2:       return 5;
      3:       return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/lgs_rst_sync.sv
module lgs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/lgs_w1c_flags.sv
module lgs_w1c_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] upd;

  // set has priority over clear so an event is never lost
  always_comb begin
    upd    = set_i | clr_i;
    flag_d = set_i | (flag_q & ~clr_i);
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (upd[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lgs_slot_mirror.sv
module lgs_slot_mirror #(
  parameter int FW  = 3,
  parameter int NIN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_vld,
  input  logic [FW:0]    slot_bits,
  input  logic [NIN-1:0] rdy_i,
  output logic [FW-1:0]  fld_o,
  output logic [NIN-1:0] rdy_o,
  output logic           gpi_evt_o
);
  logic [FW-1:0]  fld_q, fld_d;
  logic [NIN-1:0] rdy_q, rdy_d;

  always_comb begin
    fld_d = slot_bits[FW:1];
    rdy_d = rdy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fld_q <= '0;
    else if (slot_vld) fld_q <= fld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= rdy_d;
  end

  assign fld_o     = fld_q;
  assign rdy_o     = rdy_q;
  assign gpi_evt_o = slot_vld & slot_bits[0];
endmodule

// File: rtl/lgs_chan_sum.sv
module lgs_chan_sum #(
  parameter int NCH = 5,
  parameter int SW  = 3
) (
  input  logic [NCH*SW-1:0] sts_i,
  output logic [NCH-1:0]    sum_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign sum_o[k] = |sts_i[k*SW +: SW];
  end
endmodule

// File: rtl/lnk_gsts_reg.sv
module lnk_gsts_reg #(
  parameter int CH_STS_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pwr_rst_n,
  input  logic                             wr_en,
  input  logic [lgs_pkg::REG_W-1:0]        wr_data,
  output logic [lgs_pkg::REG_W-1:0]        rd_data,
  input  logic                             rd_timeout,
  input  logic [lgs_pkg::NUM_IN-1:0]       resume_evt,
  input  logic                             slot_vld,
  input  logic [lgs_pkg::FLD_W:0]          slot_bits,
  input  logic [lgs_pkg::NUM_IN-1:0]       codec_rdy,
  input  logic [lgs_pkg::NUM_CH*CH_STS_W-1:0] chan_sts
);
  import lgs_pkg::*;

  logic rst_core_n;
  logic rst_mir_n;
  logic mir_arst_n;

  logic [NUM_STK-1:0] stk_set, stk_clr, stk_q;
  logic [FLD_W-1:0]   fld;
  logic [NUM_IN-1:0]  rdy;
  logic [NUM_CH-1:0]  sum;
  logic               gpi_evt;
  logic [REG_W-1:0]   rd_d;
  logic               unused_wr_bits;

  assign mir_arst_n = rst_n & pwr_rst_n;

  lgs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_core (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_core_n)
  );

  lgs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_mir (
    .clk(clk), .arst_n(mir_arst_n), .srst_n(rst_mir_n)
  );

  always_comb begin
    stk_set           = '0;
    stk_set[STK_TMO]  = rd_timeout;
    stk_set[STK_RES1] = resume_evt[1];
    stk_set[STK_RES0] = resume_evt[0];
    stk_set[STK_GPI]  = gpi_evt;
    stk_clr           = '0;
    stk_clr[STK_TMO]  = wr_en & wr_data[B_TMO];
    stk_clr[STK_RES1] = wr_en & wr_data[B_RES1];
    stk_clr[STK_RES0] = wr_en & wr_data[B_RES0];
    stk_clr[STK_GPI]  = wr_en & wr_data[B_GPI];
  end

  assign unused_wr_bits = &{1'b0, wr_data[14:12], wr_data[9:1]};

  lgs_w1c_flags #(.N(NUM_STK)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .set_i(stk_set), .clr_i(stk_clr), .flag_o(stk_q)
  );

  lgs_slot_mirror #(.FW(FLD_W), .NIN(NUM_IN)) u_mirror (
    .clk(clk), .rst_n(rst_mir_n), .slot_vld(slot_vld), .slot_bits(slot_bits),
    .rdy_i(codec_rdy), .fld_o(fld), .rdy_o(rdy), .gpi_evt_o(gpi_evt)
  );

  lgs_chan_sum #(.NCH(NUM_CH), .SW(CH_STS_W)) u_sum (
    .sts_i(chan_sts), .sum_o(sum)
  );

  always_comb begin
    rd_d                    = '0;
    rd_d[B_TMO]             = stk_q[STK_TMO];
    rd_d[B_FLD_HI:B_FLD_LO] = fld;
    rd_d[B_RES1]            = stk_q[STK_RES1];
    rd_d[B_RES0]            = stk_q[STK_RES0];
    rd_d[B_RDY_HI:B_RDY_LO] = rdy;
    rd_d[B_GPI]             = stk_q[STK_GPI];
    for (int k = 0; k < NUM_CH; k++) begin
      rd_d[chan_bit(k)] = sum[k];
    end
  end

  assign rd_data = rd_d;
endmodule

// File: rtl/lnk_gsts_chk.sv
module lnk_gsts_chk #(
  parameter int CH_STS_W = 3
) (
  input logic                                 clk,
  input logic                                 core_n,
  input logic                                 mir_n,
  input logic                                 wr_en,
  input logic [lgs_pkg::REG_W-1:0]            wr_data,
  input logic [lgs_pkg::REG_W-1:0]            rd_data,
  input logic                                 rd_timeout,
  input logic [lgs_pkg::NUM_IN-1:0]           resume_evt,
  input logic                                 slot_vld,
  input logic [lgs_pkg::FLD_W:0]              slot_bits,
  input logic [lgs_pkg::NUM_IN-1:0]           codec_rdy,
  input logic [lgs_pkg::NUM_CH*CH_STS_W-1:0]  chan_sts
);
  AST_TMO_SET: assert property (@(posedge clk) disable iff (!core_n)
    rd_timeout |=> rd_data[15]); // R2
  AST_RES1_SET: assert property (@(posedge clk) disable iff (!core_n)
    resume_evt[1] |=> rd_data[11]); // R3
  AST_RES0_SET: assert property (@(posedge clk) disable iff (!core_n)
    resume_evt[0] |=> rd_data[10]); // R3
  AST_GPI_SET: assert property (@(posedge clk) disable iff (!core_n)
    (slot_vld && slot_bits[0]) |=> rd_data[0]); // R4
  AST_TMO_CLR: assert property (@(posedge clk) disable iff (!core_n)
    (wr_en && wr_data[15] && !rd_timeout) |=> !rd_data[15]); // R5
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!core_n)
    (rd_data[15] && !(wr_en && wr_data[15])) |=> rd_data[15]); // R5
  AST_FLD_LOAD: assert property (@(posedge clk) disable iff (!mir_n)
    slot_vld |=> (rd_data[14:12] == $past(slot_bits[3:1]))); // R6
  AST_FLD_HOLD: assert property (@(posedge clk) disable iff (!mir_n)
    !slot_vld |=> $stable(rd_data[14:12])); // R6
  AST_RDY_LAG: assert property (@(posedge clk) disable iff (!mir_n)
    mir_n |=> (rd_data[9:8] == $past(codec_rdy))); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!core_n)
    rd_data[4:3] == 2'b00); // R9

  for (genvar k = 0; k < lgs_pkg::NUM_CH; k++) begin : g_sum
    localparam int P = lgs_pkg::chan_bit(k);
    AST_CHAN_SUM: assert property (@(posedge clk) disable iff (!core_n)
      rd_data[P] == (|chan_sts[k*CH_STS_W +: CH_STS_W])); // R8
  end
endmodule

bind lnk_gsts_reg lnk_gsts_chk #(.CH_STS_W(CH_STS_W)) chk_i (
  .clk(clk), .core_n(rst_core_n), .mir_n(rst_mir_n), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .rd_timeout(rd_timeout),
  .resume_evt(resume_evt), .slot_vld(slot_vld), .slot_bits(slot_bits),
  .codec_rdy(codec_rdy), .chan_sts(chan_sts)
);

// File: tb/lnk_gsts_reg_tb_top.sv
module lnk_gsts_reg_tb_top;
  localparam int SW  = 3;
  localparam int NCH = 5;

  logic              clk = 1'b0;
  logic              rst_n, pwr_rst_n, wr_en, rd_timeout, slot_vld;
  logic [15:0]       wr_data, rd_data;
  logic [1:0]        resume_evt, codec_rdy;
  logic [3:0]        slot_bits;
  logic [NCH*SW-1:0] chan_sts;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lnk_gsts_reg #(.CH_STS_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_rst_n(pwr_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rd_timeout(rd_timeout),
    .resume_evt(resume_evt), .slot_vld(slot_vld), .slot_bits(slot_bits),
    .codec_rdy(codec_rdy), .chan_sts(chan_sts)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] sum_exp(input logic [NCH*SW-1:0] s);
    logic [15:0] e;
    int pos [NCH] = '{7, 6, 5, 2, 1};
    e = '0;
    for (int k = 0; k < NCH; k++) begin
      if (((s >> (k*SW)) & ((1 << SW) - 1)) != 0) e[pos[k]] = 1'b1;
    end
    return e;
  endfunction

  // map a 4-bit mask onto sticky positions 15, 11, 10, 0
  function automatic logic [15:0] stk_map(input logic [3:0] m);
    logic [15:0] e;
    e = '0;
    e[15] = m[3];
    e[11] = m[2];
    e[10] = m[1];
    e[0]  = m[0];
    return e;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, all requirements affected");
    finish_run();
  end

  initial begin
    logic [15:0] keep;
    rst_n = 1'b0; pwr_rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd_timeout = 1'b0; resume_evt = '0; slot_vld = 1'b0; slot_bits = '0;
    codec_rdy = '0; chan_sts = '0;
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1; pwr_rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 reset state", 16'h0000);

    // R8: exhaustive summary sweep, no register on the path
    for (int v = 0; v < (1 << (NCH*SW)); v++) begin
      chan_sts = v[NCH*SW-1:0];
      #1;
      chk("R8 channel summary", sum_exp(chan_sts));
    end
    chan_sts = '0;
    #1;

    // R7: codec ready mirror, one clock lag
    for (int v = 0; v < 4; v++) begin
      codec_rdy = v[1:0];
      tick();
      chk("R7 codec ready", {6'b0, v[1:0], 8'h00});
    end
    codec_rdy = '0;
    tick();

    // R6 / R4: all slot values, then hold with slot_vld low
    for (int v = 0; v < 16; v++) begin
      slot_vld = 1'b1; slot_bits = v[3:0];
      tick();
      slot_vld = 1'b0;
      chk("R6 R4 slot capture", {1'b0, v[3:1], 11'h0, (v >= 1) ? 1'b1 : 1'b0});
      slot_bits = ~v[3:0];
      tick();
      chk("R6 slot hold", {1'b0, v[3:1], 11'h0, (v >= 1) ? 1'b1 : 1'b0});
    end
    wr_en = 1'b1; wr_data = 16'h0001;
    tick();
    wr_en = 1'b0;
    chk("R5 gpi clear", 16'h7000);

    // R2 / R3: individual sticky sets
    rd_timeout = 1'b1;
    tick();
    rd_timeout = 1'b0;
    chk("R2 timeout set", 16'hF000);
    repeat (3) tick();
    chk("R2 timeout held", 16'hF000);
    resume_evt = 2'b01;
    tick();
    resume_evt = 2'b00;
    chk("R3 resume0 set", 16'hF400);
    resume_evt = 2'b10;
    tick();
    resume_evt = 2'b00;
    chk("R3 resume1 set", 16'hFC00);

    // R5: every write mask over the four sticky bits
    for (int m = 0; m < 16; m++) begin
      rd_timeout = 1'b1; resume_evt = 2'b11; slot_vld = 1'b1; slot_bits = 4'hF;
      tick();
      rd_timeout = 1'b0; resume_evt = 2'b00; slot_vld = 1'b0;
      wr_en = 1'b1; wr_data = stk_map(m[3:0]);
      tick();
      wr_en = 1'b0;
      chk("R5 write-one-clear mask", 16'h7000 | stk_map(~m[3:0]));
    end

    // R9: write all ones, read-only and reserved bits unaffected
    wr_en = 1'b1; wr_data = 16'hFFFF; codec_rdy = 2'b11;
    tick();
    wr_en = 1'b0;
    chk("R9 read-only ignore", 16'h7300);
    codec_rdy = 2'b00;
    tick();
    chk("R9 reserved zero", 16'h7000);

    // R5: set wins over same-cycle clear
    rd_timeout = 1'b1; wr_en = 1'b1; wr_data = 16'h8000;
    tick();
    rd_timeout = 1'b0; wr_en = 1'b0;
    chk("R5 set wins timeout", 16'hF000);
    resume_evt = 2'b01; wr_en = 1'b1; wr_data = 16'h0400;
    tick();
    resume_evt = 2'b00; wr_en = 1'b0;
    chk("R5 set wins resume0", 16'hF400);
    slot_vld = 1'b1; slot_bits = 4'hF; wr_en = 1'b1; wr_data = 16'h0001;
    tick();
    slot_vld = 1'b0; wr_en = 1'b0;
    chk("R5 set wins gpi", 16'hF401);

    // R10: power-state reset keeps sticky bits, clears mirrors
    codec_rdy = 2'b11;
    tick();
    chk("R10 before power reset", 16'hF701);
    keep = 16'h8401;
    pwr_rst_n = 1'b0;
    tick();
    chk("R10 during power reset", keep);
    pwr_rst_n = 1'b1;
    repeat (4) tick();
    chk("R10 after power reset", keep | 16'h0300);

    // R10 / R1: full reset clears everything
    rst_n = 1'b0;
    tick();
    chk("R10 full reset clears", 16'h0000);
    codec_rdy = 2'b00;
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after second reset", 16'h0000);

    finish_run();
  end
endmodule